// File: doc/BRIEF.md
# PLL Start-Up Boost Controller

This block speeds up PLL acquisition by driving a level onto the loop-filter pin right after start-up. It does this only once. It watches single-cycle edge pulses from the reference path and from the divided-VCO path, and measures how many system-clock cycles separate each reference edge from its matching VCO edge. While that separation stays at or above a fixed window, the block drives the pin. The level is high when the reference edge came first and low when the VCO edge came first.

The first time a pair of edges closes inside the window, the block releases the pin to high impedance and stays released. Dropping the enable input while boosting also releases the pin for good. After that, neither loss of lock, nor new control writes, nor further enable pulses can re-arm it. Only a power-on reset returns the machine to its waiting state. The surrounding pad logic turns the level and output-enable into a tristate pin.

Top module: `pll_boost_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low, active low), `boost_oe` is 0 and `boost_lvl` is 1.
- R2: In the waiting state, `boost_oe` stays 0 until `op_en` is sampled high on a clock edge where it was low on the previous edge. It becomes 1 after that edge. `op_en` already high at the first edge after reset counts as a rise.
- R3: While boosting, an edge that opens a pair sets `boost_lvl` after the sampling edge. A reference edge sets it to 1 and a VCO edge sets it to 0. Without edges, the level holds.
- R4: A pair that closes with a lag of k clock cycles, where k < 32, ends boosting. `boost_oe` is 0 after the edge that samples the closing pulse. Lag is the number of edges from the opening sample to the closing sample.
- R5: A pair whose lag is 32 or more keeps `boost_oe` at 1.
- R6: A reference and a VCO pulse in the same cycle with no pair open count as lag 0 and end boosting.
- R7: `op_en` sampled low while boosting ends boosting on that edge.
- R8: Once boosting has ended, `boost_oe` stays 0 for any `op_en`, `ref_pulse` or `vco_pulse` activity until the next power-on reset. After that reset a new boost can run.
- R9: A second edge of the same kind as an open pair's opener restarts the lag count from that edge.
- R10: With a pair open, simultaneous reference and VCO pulses close that pair with its current lag and open a new pair led by the same kind of edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| op_en | input | 1 | Operate enable; its first rise starts boosting |
| ref_pulse | input | 1 | One-cycle pulse per reference edge |
| vco_pulse | input | 1 | One-cycle pulse per divided-VCO edge |
| boost_lvl | output | 1 | Level to drive on the filter pin while enabled |
| boost_oe | output | 1 | Output-enable of the tristate filter pin |

## Verification
Closing one pair and opening the next can happen in the same cycle. This occurs when both pulses arrive together, with or without a pair already open. The bench drives coincident pulses in both cases. With no pair open, the release must follow at once. With a reference-led pair open at lag 35, the pin must stay driven and high. A short VCO lag afterwards then shows that the new pair was measured from the coincident edge and not from the old one.

// File: rtl/pll_boost_ctrl.sv
module pll_boost_ctrl #(
  parameter int WIN_CYCLES = 32,
  localparam int CNT_W = $clog2(WIN_CYCLES + 1)
) (
  input  logic clk,
  input  logic por_n,
  input  logic op_en,
  input  logic ref_pulse,
  input  logic vco_pulse,
  output logic boost_lvl,
  output logic boost_oe
);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_BOOST = 2'd1, ST_DONE = 2'd2} state_t;
  localparam logic [CNT_W-1:0] WIN = CNT_W'(WIN_CYCLES);

  state_t           state_q;
  logic             en_q, pend_q, lead_ref_q;
  logic [CNT_W-1:0] lag_q;

  wire en_rise = op_en & ~en_q;
  wire both    = ref_pulse & vco_pulse;
  wire closing = pend_q & (lead_ref_q ? vco_pulse : ref_pulse);
  wire opener  = pend_q ? (lead_ref_q ? ref_pulse : vco_pulse) : (ref_pulse ^ vco_pulse);
  wire hit     = (closing & (lag_q < WIN)) | (~pend_q & both);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q    <= ST_IDLE;
      en_q       <= 1'b0;
      pend_q     <= 1'b0;
      lead_ref_q <= 1'b1;
      lag_q      <= '0;
    end else begin
      en_q <= op_en;
      unique case (state_q)
        ST_IDLE:  if (en_rise) state_q <= ST_BOOST;
        ST_BOOST: if (!op_en || hit) state_q <= ST_DONE;
        default:  state_q <= ST_DONE;
      endcase
      if (state_q == ST_BOOST) begin
        if (opener) begin
          pend_q <= 1'b1;
          lag_q  <= CNT_W'(1);
          if (!pend_q) lead_ref_q <= ref_pulse;
        end else if (closing) begin
          pend_q <= 1'b0;
        end else if (pend_q && lag_q < WIN) begin
          lag_q <= lag_q + CNT_W'(1);
        end
      end
    end
  end

  assign boost_lvl = lead_ref_q;
  assign boost_oe  = (state_q == ST_BOOST);

endmodule

// File: rtl/pll_boost_chk.sv
module pll_boost_chk (
  input logic       clk,
  input logic       por_n,
  input logic       op_en,
  input logic       ref_pulse,
  input logic       vco_pulse,
  input logic       boost_lvl,
  input logic       boost_oe,
  input logic [1:0] state_q,
  input logic       pend_q
);

  // R2
  oe_from_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(boost_oe) |-> $past(state_q) == 2'd0);

  // R3
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    boost_oe && !ref_pulse && !vco_pulse |=> $stable(boost_lvl));

  // R6
  coincident_chk: assert property (@(posedge clk) disable iff (!por_n)
    state_q == 2'd1 && !pend_q && ref_pulse && vco_pulse |=> !boost_oe);

  // R7
  en_drop_chk: assert property (@(posedge clk) disable iff (!por_n)
    boost_oe && !op_en |=> !boost_oe);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    state_q == 2'd2 |=> state_q == 2'd2 && !boost_oe);

endmodule

bind pll_boost_ctrl pll_boost_chk u_chk (
  .clk(clk), .por_n(por_n), .op_en(op_en), .ref_pulse(ref_pulse),
  .vco_pulse(vco_pulse), .boost_lvl(boost_lvl), .boost_oe(boost_oe),
  .state_q(state_q), .pend_q(pend_q)
);

// File: tb/pll_boost_ctrl_bench.sv
module pll_boost_ctrl_bench;
  logic clk = 1'b0;
  logic por_n = 1'b0, op_en = 1'b0, ref_pulse = 1'b0, vco_pulse = 1'b0;
  logic boost_lvl, boost_oe;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  pll_boost_ctrl u_pll_boost_ctrl (
    .clk(clk), .por_n(por_n), .op_en(op_en), .ref_pulse(ref_pulse),
    .vco_pulse(vco_pulse), .boost_lvl(boost_lvl), .boost_oe(boost_oe)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic r, input logic v);
    ref_pulse = r; vco_pulse = v;
    @(negedge clk);
    ref_pulse = 0; vco_pulse = 0;
  endtask

  task automatic power_on();
    @(negedge clk);
    por_n = 0; op_en = 0; ref_pulse = 0; vco_pulse = 0;
    idle(3);
    por_n = 1;
    idle(1);
  endtask

  task automatic start();
    op_en = 1;
    idle(1);
  endtask

  task automatic t_reset();
    power_on();
    check("R1 oe", boost_oe, 0);
    check("R1 lvl", boost_lvl, 1);
    idle(5);
    check("R2 waits for enable", boost_oe, 0);
    pulse(1, 1);
    check("R2 edges ignored while waiting", boost_oe, 0);
    start();
    check("R2 enable rise starts", boost_oe, 1);
  endtask

  task automatic t_lead_lag();
    power_on(); start();
    pulse(0, 1);
    check("R3 vco lead lvl", boost_lvl, 0);
    idle(39); pulse(1, 0);
    check("R5 lag 40 keeps oe", boost_oe, 1);
    pulse(1, 0);
    check("R3 ref lead lvl", boost_lvl, 1);
    idle(30); pulse(0, 1);
    check("R4 lag 31 releases", boost_oe, 0);
  endtask

  task automatic t_exact_window();
    power_on(); start();
    pulse(1, 0); idle(31); pulse(0, 1);
    check("R5 lag 32 keeps oe", boost_oe, 1);
    pulse(0, 1); idle(3); pulse(1, 0);
    check("R4 lag 4 releases", boost_oe, 0);
  endtask

  task automatic t_coincident();
    power_on(); start();
    pulse(1, 1);
    check("R6 coincident releases", boost_oe, 0);
  endtask

  task automatic t_en_drop();
    power_on(); start();
    pulse(1, 0); idle(2);
    op_en = 0; idle(1);
    check("R7 enable drop releases", boost_oe, 0);
    op_en = 1; idle(2);
    check("R8 re-enable ignored", boost_oe, 0);
    pulse(0, 1); idle(60); pulse(1, 0);
    check("R8 lock loss ignored", boost_oe, 0);
    power_on(); start();
    check("R8 por re-arms", boost_oe, 1);
  endtask

  task automatic t_restart();
    power_on(); start();
    pulse(1, 0); idle(40); pulse(1, 0);
    check("R9 still boosting", boost_oe, 1);
    idle(5); pulse(0, 1);
    check("R9 restart measured lag 6", boost_oe, 0);
  endtask

  task automatic t_reopen();
    power_on(); start();
    pulse(1, 0); idle(34); pulse(1, 1);
    check("R10 lag 35 close keeps oe", boost_oe, 1);
    check("R10 new pair ref led", boost_lvl, 1);
    idle(2); pulse(0, 1);
    check("R10 new pair lag 3 releases", boost_oe, 0);
  endtask

  initial begin
    t_reset();
    t_lead_lag();
    t_exact_window();
    t_coincident();
    t_en_drop();
    t_restart();
    t_reopen();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule